// File: doc/BRIEF.md
# Vertical Microcoded Multicycle Controller

This block is the control unit of a multicycle processor whose datapath has one shared memory, one register file and one ALU. A micro-address register selects a word from a small control store; each word is a packed 14-bit vertical microinstruction. Its narrow, encoded fields are expanded by local decode into the individual datapath control lines: ALU operation, operand selects, immediate extension, register-write controls, memory controls, IR write and PC write. A sequencing field picks the next micro-address. It can step to the following word, dispatch through an opcode table, or return to the fetch word.

The store holds routines for instruction fetch, decode and five instruction classes: register-register ALU, OR-immediate, load word, store word and branch-on-equal. The datapath supplies the ALU zero flag, which qualifies the branch PC write, and a memory wait flag. While the wait flag is high, any word that touches memory is held, and its state-changing writes are withheld.

Top module: `ucode_ctrl`

## Requirements
- R1: While rst_ni is low the micro-address is 0 (the fetch word). Once rst_ni is high it advances only on rising clk_i edges.
- R2: Word layout, from the MSB down: alu[13:12], src1[11], src2[10:8], dest[7:6], mem[5:4], irw[3], pcw[2], seq[1:0]. alu_op_o copies alu: 00 add, 01 subtract, 10 function code, 11 OR. alu_sel_a_o copies src1: 0 PC, 1 rs.
- R3: src2 decodes to {alu_sel_b_o, ext_op_o}: 001 gives {00,0} (constant 4), 010 gives {01,0} (rt), 011 gives {10,1} (sign-extended shifted by 2), 100 gives {11,1} (sign-extended), 111 gives {11,0} (zero-extended). Any other code gives {00,0}.
- R4: dest decodes to {reg_wr_o, mem_to_reg_o, reg_dst_o}: 00 gives 000, 01 gives 101 (rd from ALUout), 10 gives 100 (rt from ALUout), 11 gives 110 (rt from memory).
- R5: mem decodes to {mem_rd_o, mem_wr_o, iord_o}: 00 gives 000, 01 gives 100 (read at PC), 10 gives 101 (read at ALUout), 11 gives 011 (write at ALUout).
- R6: seq: 00 goes to the next word, 01 dispatches on opcode_i, and 10 or 11 returns to word 0.
- R7: Dispatch targets by opcode: 000000 goes to word 4, 000100 to 2, 001101 to 6, 100011 to 8 and 101011 to 11. Any other opcode goes to word 0.
- R8: The fetch word adds PC and 4, reads memory at PC, writes IR and writes PC unconditionally with pc_src_o=0, then steps to the decode word. That word adds PC and the shifted sign-extended immediate and dispatches.
- R9: When pcw is set, a word whose seq is 00 writes PC unconditionally. Otherwise the write is conditional: pc_wr_o follows zero_i and pc_src_o=1 (ALUout). The branch word subtracts rt from rs this way, then returns to fetch.
- R10: The register-register routine is a function-code ALU operation on rs and rt, then a write of rd from ALUout. The OR-immediate routine is an OR of rs with the zero-extended immediate, then a write of rt from ALUout. Both then return to fetch.
- R11: The load routine adds rs and the sign-extended immediate, reads memory at ALUout, writes rt from memory, then fetches. The store routine does the same add, then writes memory at ALUout, then fetches.
- R12: While mem_wait_i is high on a word with mem not 00, the micro-address holds and reg_wr_o, ir_wr_o and pc_wr_o are 0. Memory strobes and all other lines keep their decoded values.
- R13: mem_wait_i has no effect on words whose mem field is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| zero_i | input | 1 | ALU zero flag |
| mem_wait_i | input | 1 | Memory not ready |
| alu_op_o | output | 2 | ALU operation |
| alu_sel_a_o | output | 1 | First ALU operand select |
| alu_sel_b_o | output | 2 | Second ALU operand select |
| ext_op_o | output | 1 | Immediate sign extension enable |
| reg_wr_o | output | 1 | Register file write |
| mem_to_reg_o | output | 1 | Register write data from memory |
| reg_dst_o | output | 1 | Register destination is rd |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| iord_o | output | 1 | Memory address from ALUout |
| ir_wr_o | output | 1 | Instruction register write |
| pc_wr_o | output | 1 | PC write, already qualified by zero flag |
| pc_src_o | output | 1 | PC source is ALUout |

## Verification
The fetch word issues a memory read together with the IR and PC writes that depend on it. A wait stall can therefore land in the same cycle as those writes. The bench raises mem_wait_i during fetch and expects a control vector with the read still on, IR and PC writes off, and the same fetch word repeated in the next cycle. It applies the same kind of stall to the load read and the store write. It also raises the wait flag on decode, branch and write-back words, where the vector must match the unstalled one and the routine must move on.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
  localparam int OPC_W = 6;

  // field codes
  localparam logic [1:0] ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNC = 2'b10, ALU_OR = 2'b11;
  localparam logic [2:0] S2_NONE = 3'b000, S2_FOUR = 3'b001, S2_RT = 3'b010,
                         S2_ESHL = 3'b011, S2_SEXT = 3'b100, S2_ZEXT = 3'b111;
  localparam logic [1:0] DST_NONE = 2'b00, DST_RD_ALU = 2'b01, DST_RT_ALU = 2'b10, DST_RT_MEM = 2'b11;
  localparam logic [1:0] MEM_NONE = 2'b00, MEM_RD_PC = 2'b01, MEM_RD_ALU = 2'b10, MEM_WR_ALU = 2'b11;
  localparam logic [1:0] SEQ_NEXT = 2'b00, SEQ_DISP = 2'b01, SEQ_FETCH = 2'b10;

  // dispatch opcodes
  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000, OP_BEQ = 6'b000100, OP_ORI = 6'b001101,
                               OP_LW = 6'b100011, OP_SW = 6'b101011;

  // routine entry words
  localparam int UA_FETCH = 0, UA_DECODE = 1, UA_BEQ = 2, UA_RTYPE = 4, UA_RTYPE_WB = 5,
                 UA_ORI = 6, UA_ORI_WB = 7, UA_LW = 8, UA_LW_MEM = 9, UA_LW_WB = 10,
                 UA_SW = 11, UA_SW_MEM = 12;

  typedef struct packed {
    logic [1:0] alu;
    logic       src1;
    logic [2:0] src2;
    logic [1:0] dest;
    logic [1:0] mem;
    logic       irw;
    logic       pcw;
    logic [1:0] seq;
  } uword_t;

  localparam int UWORD_W = $bits(uword_t);
endpackage

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic [UADDR_W-1:0] uaddr_i,
  output uword_t             word_o
);
  function automatic uword_t mk(logic [1:0] alu, logic src1, logic [2:0] src2, logic [1:0] dest,
                                logic [1:0] mem, logic irw, logic pcw, logic [1:0] seq);
    mk = '{alu: alu, src1: src1, src2: src2, dest: dest, mem: mem, irw: irw, pcw: pcw, seq: seq};
  endfunction

  always_comb begin
    case (int'(uaddr_i))
      UA_FETCH:    word_o = mk(ALU_ADD,  1'b0, S2_FOUR, DST_NONE,   MEM_RD_PC,  1'b1, 1'b1, SEQ_NEXT);
      UA_DECODE:   word_o = mk(ALU_ADD,  1'b0, S2_ESHL, DST_NONE,   MEM_NONE,   1'b0, 1'b0, SEQ_DISP);
      UA_BEQ:      word_o = mk(ALU_SUB,  1'b1, S2_RT,   DST_NONE,   MEM_NONE,   1'b0, 1'b1, SEQ_FETCH);
      UA_RTYPE:    word_o = mk(ALU_FUNC, 1'b1, S2_RT,   DST_NONE,   MEM_NONE,   1'b0, 1'b0, SEQ_NEXT);
      UA_RTYPE_WB: word_o = mk(ALU_ADD,  1'b0, S2_NONE, DST_RD_ALU, MEM_NONE,   1'b0, 1'b0, SEQ_FETCH);
      UA_ORI:      word_o = mk(ALU_OR,   1'b1, S2_ZEXT, DST_NONE,   MEM_NONE,   1'b0, 1'b0, SEQ_NEXT);
      UA_ORI_WB:   word_o = mk(ALU_ADD,  1'b0, S2_NONE, DST_RT_ALU, MEM_NONE,   1'b0, 1'b0, SEQ_FETCH);
      UA_LW:       word_o = mk(ALU_ADD,  1'b1, S2_SEXT, DST_NONE,   MEM_NONE,   1'b0, 1'b0, SEQ_NEXT);
      UA_LW_MEM:   word_o = mk(ALU_ADD,  1'b0, S2_NONE, DST_NONE,   MEM_RD_ALU, 1'b0, 1'b0, SEQ_NEXT);
      UA_LW_WB:    word_o = mk(ALU_ADD,  1'b0, S2_NONE, DST_RT_MEM, MEM_NONE,   1'b0, 1'b0, SEQ_FETCH);
      UA_SW:       word_o = mk(ALU_ADD,  1'b1, S2_SEXT, DST_NONE,   MEM_NONE,   1'b0, 1'b0, SEQ_NEXT);
      UA_SW_MEM:   word_o = mk(ALU_ADD,  1'b0, S2_NONE, DST_NONE,   MEM_WR_ALU, 1'b0, 1'b0, SEQ_FETCH);
      default:     word_o = mk(ALU_ADD,  1'b0, S2_NONE, DST_NONE,   MEM_NONE,   1'b0, 1'b0, SEQ_FETCH);
    endcase
  end
endmodule

// File: rtl/ucode_field_dec.sv
module ucode_field_dec
  import ucode_pkg::*;
(
  input  uword_t     word_i,
  input  logic       zero_i,
  input  logic       mem_wait_i,
  output logic       stall_o,
  output logic [1:0] alu_op_o,
  output logic       alu_sel_a_o,
  output logic [1:0] alu_sel_b_o,
  output logic       ext_op_o,
  output logic       reg_wr_o,
  output logic       mem_to_reg_o,
  output logic       reg_dst_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       iord_o,
  output logic       ir_wr_o,
  output logic       pc_wr_o,
  output logic       pc_src_o
);
  logic reg_wr_raw, pc_cond;

  assign stall_o     = (word_i.mem != MEM_NONE) && mem_wait_i;
  assign alu_op_o    = word_i.alu;
  assign alu_sel_a_o = word_i.src1;

  always_comb begin
    case (word_i.src2)
      S2_FOUR: {alu_sel_b_o, ext_op_o} = 3'b00_0;
      S2_RT:   {alu_sel_b_o, ext_op_o} = 3'b01_0;
      S2_ESHL: {alu_sel_b_o, ext_op_o} = 3'b10_1;
      S2_SEXT: {alu_sel_b_o, ext_op_o} = 3'b11_1;
      S2_ZEXT: {alu_sel_b_o, ext_op_o} = 3'b11_0;
      default: {alu_sel_b_o, ext_op_o} = 3'b00_0;
    endcase
  end

  always_comb begin
    case (word_i.dest)
      DST_RD_ALU: {reg_wr_raw, mem_to_reg_o, reg_dst_o} = 3'b101;
      DST_RT_ALU: {reg_wr_raw, mem_to_reg_o, reg_dst_o} = 3'b100;
      DST_RT_MEM: {reg_wr_raw, mem_to_reg_o, reg_dst_o} = 3'b110;
      default:    {reg_wr_raw, mem_to_reg_o, reg_dst_o} = 3'b000;
    endcase
  end

  always_comb begin
    case (word_i.mem)
      MEM_RD_PC:  {mem_rd_o, mem_wr_o, iord_o} = 3'b100;
      MEM_RD_ALU: {mem_rd_o, mem_wr_o, iord_o} = 3'b101;
      MEM_WR_ALU: {mem_rd_o, mem_wr_o, iord_o} = 3'b011;
      default:    {mem_rd_o, mem_wr_o, iord_o} = 3'b000;
    endcase
  end

  // pcw on a stepping word is the fetch increment; otherwise it is the branch
  assign pc_cond  = word_i.pcw && (word_i.seq != SEQ_NEXT);
  assign pc_src_o = pc_cond;
  assign reg_wr_o = reg_wr_raw && !stall_o;
  assign ir_wr_o  = word_i.irw && !stall_o;
  assign pc_wr_o  = !stall_o && ((word_i.pcw && !pc_cond) || (pc_cond && zero_i));
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         seq_i,
  input  logic               stall_i,
  input  logic [OPC_W-1:0]   opcode_i,
  output logic [UADDR_W-1:0] upc_o
);
  logic [UADDR_W-1:0] upc_q, upc_d, disp;

  always_comb begin
    case (opcode_i)
      OP_RTYPE: disp = UADDR_W'(UA_RTYPE);
      OP_BEQ:   disp = UADDR_W'(UA_BEQ);
      OP_ORI:   disp = UADDR_W'(UA_ORI);
      OP_LW:    disp = UADDR_W'(UA_LW);
      OP_SW:    disp = UADDR_W'(UA_SW);
      default:  disp = UADDR_W'(UA_FETCH);
    endcase
  end

  always_comb begin
    if (stall_i)                 upc_d = upc_q;
    else if (seq_i == SEQ_NEXT)  upc_d = upc_q + 1'b1;
    else if (seq_i == SEQ_DISP)  upc_d = disp;
    else                         upc_d = UADDR_W'(UA_FETCH);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= '0;
    else         upc_q <= upc_d;
  end

  assign upc_o = upc_q;
endmodule

// File: rtl/ucode_ctrl.sv
module ucode_ctrl
  import ucode_pkg::*;
#(
  parameter int UADDR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             zero_i,
  input  logic             mem_wait_i,
  output logic [1:0]       alu_op_o,
  output logic             alu_sel_a_o,
  output logic [1:0]       alu_sel_b_o,
  output logic             ext_op_o,
  output logic             reg_wr_o,
  output logic             mem_to_reg_o,
  output logic             reg_dst_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             iord_o,
  output logic             ir_wr_o,
  output logic             pc_wr_o,
  output logic             pc_src_o
);
  logic [UADDR_W-1:0] upc_q;
  uword_t             word;
  logic               stall;

  ucode_seq #(.UADDR_W(UADDR_W)) seq_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .seq_i(word.seq), .stall_i(stall),
    .opcode_i(opcode_i), .upc_o(upc_q)
  );

  ucode_store #(.UADDR_W(UADDR_W)) store_i (.uaddr_i(upc_q), .word_o(word));

  ucode_field_dec dec_i (
    .word_i(word), .zero_i(zero_i), .mem_wait_i(mem_wait_i), .stall_o(stall),
    .alu_op_o(alu_op_o), .alu_sel_a_o(alu_sel_a_o), .alu_sel_b_o(alu_sel_b_o),
    .ext_op_o(ext_op_o), .reg_wr_o(reg_wr_o), .mem_to_reg_o(mem_to_reg_o),
    .reg_dst_o(reg_dst_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .iord_o(iord_o),
    .ir_wr_o(ir_wr_o), .pc_wr_o(pc_wr_o), .pc_src_o(pc_src_o)
  );
endmodule

// File: rtl/ucode_ctrl_chk.sv
module ucode_ctrl_chk #(
  parameter int UADDR_W = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               zero_i,
  input logic               mem_wait_i,
  input logic               reg_wr_o,
  input logic               mem_to_reg_o,
  input logic               mem_rd_o,
  input logic               mem_wr_o,
  input logic               iord_o,
  input logic               ir_wr_o,
  input logic               pc_wr_o,
  input logic               pc_src_o,
  input logic [UADDR_W-1:0] upc_q
);
  assert_mem_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_stall_no_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && mem_wait_i) |-> !(reg_wr_o || ir_wr_o || pc_wr_o));

  assert_stall_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && mem_wait_i) |=> $stable(upc_q));

  assert_branch_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_o && pc_src_o) |-> zero_i);

  assert_ir_from_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |-> (mem_rd_o && !iord_o && pc_wr_o && !pc_src_o));

  assert_fetch_to_decode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> (upc_q == UADDR_W'(1)));

  assert_memdata_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_to_reg_o |-> (reg_wr_o || !mem_wait_i || !(mem_rd_o || mem_wr_o)));
endmodule

bind ucode_ctrl ucode_ctrl_chk #(.UADDR_W(UADDR_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .zero_i(zero_i), .mem_wait_i(mem_wait_i),
  .reg_wr_o(reg_wr_o), .mem_to_reg_o(mem_to_reg_o), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o), .iord_o(iord_o), .ir_wr_o(ir_wr_o), .pc_wr_o(pc_wr_o),
  .pc_src_o(pc_src_o), .upc_q(upc_q)
);

// File: tb/ucode_ctrl_tb_top.sv
module ucode_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'd0;
  logic zero = 1'b0;
  logic mwait = 1'b1;
  logic [1:0] alu_op, alu_sel_b;
  logic alu_sel_a, ext_op, reg_wr, mem_to_reg, reg_dst, mem_rd, mem_wr, iord, ir_wr, pc_wr, pc_src;
  int n_chk = 0, n_bad = 0;
  logic [14:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ucode_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode), .zero_i(zero), .mem_wait_i(mwait),
    .alu_op_o(alu_op), .alu_sel_a_o(alu_sel_a), .alu_sel_b_o(alu_sel_b), .ext_op_o(ext_op),
    .reg_wr_o(reg_wr), .mem_to_reg_o(mem_to_reg), .reg_dst_o(reg_dst), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .iord_o(iord), .ir_wr_o(ir_wr), .pc_wr_o(pc_wr), .pc_src_o(pc_src)
  );

  // {alu, sel_a, sel_b, ext, reg_wr, mem_to_reg, reg_dst, mem_rd, mem_wr, iord, ir_wr, pc_wr, pc_src}
  function automatic logic [14:0] v(logic [1:0] alu, logic sa, logic [1:0] sb, logic ext,
                                    logic [2:0] dst, logic [2:0] mem, logic irw, logic pcw, logic ps);
    v = {alu, sa, sb, ext, dst, mem, irw, pcw, ps};
  endfunction

  function automatic logic [14:0] act();
    act = {alu_op, alu_sel_a, alu_sel_b, ext_op, reg_wr, mem_to_reg, reg_dst,
           mem_rd, mem_wr, iord, ir_wr, pc_wr, pc_src};
  endfunction

  localparam logic [14:0] V_FETCH  = v(2'b00, 1'b0, 2'b00, 1'b0, 3'b000, 3'b100, 1'b1, 1'b1, 1'b0);
  localparam logic [14:0] V_FETCHW = v(2'b00, 1'b0, 2'b00, 1'b0, 3'b000, 3'b100, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_DEC    = v(2'b00, 1'b0, 2'b10, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_REX    = v(2'b10, 1'b1, 2'b01, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_RWB    = v(2'b00, 1'b0, 2'b00, 1'b0, 3'b101, 3'b000, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_OEX    = v(2'b11, 1'b1, 2'b11, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_OWB    = v(2'b00, 1'b0, 2'b00, 1'b0, 3'b100, 3'b000, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_AEX    = v(2'b00, 1'b1, 2'b11, 1'b1, 3'b000, 3'b000, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_LMEM   = v(2'b00, 1'b0, 2'b00, 1'b0, 3'b000, 3'b101, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_LWB    = v(2'b00, 1'b0, 2'b00, 1'b0, 3'b110, 3'b000, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_SMEM   = v(2'b00, 1'b0, 2'b00, 1'b0, 3'b000, 3'b011, 1'b0, 1'b0, 1'b0);
  localparam logic [14:0] V_BNT    = v(2'b01, 1'b1, 2'b01, 1'b0, 3'b000, 3'b000, 1'b0, 1'b0, 1'b1);
  localparam logic [14:0] V_BT     = v(2'b01, 1'b1, 2'b01, 1'b0, 3'b000, 3'b000, 1'b0, 1'b1, 1'b1);

  // driver: inputs for one cycle, expected control vector for that cycle
  task automatic step(logic [5:0] opc, logic z, logic w, logic [14:0] e, string tag);
    @(posedge clk); #1;
    opcode = opc; zero = z; mwait = w;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (act() !== e) begin
          n_bad++;
          $display("FAIL %s: actual=%b expected=%b", t, act(), e);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (act() !== V_FETCHW) begin  // R1: fetch word, wait high during reset
      n_bad++;
      $display("FAIL R1 reset: actual=%b expected=%b", act(), V_FETCHW);
    end
    rst_n = 1'b1;

    // R1/R8/R10 register-register routine
    step(6'b000000, 0, 0, V_FETCH, "R8 fetch");
    step(6'b000000, 0, 0, V_DEC,   "R8 decode");
    step(6'b000000, 0, 0, V_REX,   "R10 rtype exec");
    step(6'b000000, 0, 0, V_RWB,   "R10 rtype wb");
    // R10 OR-immediate
    step(6'b001101, 0, 0, V_FETCH, "R8 fetch");
    step(6'b001101, 0, 0, V_DEC,   "R8 decode");
    step(6'b001101, 0, 0, V_OEX,   "R10 ori exec");
    step(6'b001101, 0, 0, V_OWB,   "R10 ori wb");
    // R11 load with a stalled fetch and a stalled read (R12)
    step(6'b100011, 0, 1, V_FETCHW, "R12 fetch stalled");
    step(6'b100011, 0, 1, V_FETCHW, "R12 fetch held");
    step(6'b100011, 0, 0, V_FETCH,  "R12 fetch released");
    step(6'b100011, 0, 0, V_DEC,    "R8 decode");
    step(6'b100011, 0, 0, V_AEX,    "R11 lw addr");
    step(6'b100011, 0, 1, V_LMEM,   "R12 lw read stalled");
    step(6'b100011, 0, 0, V_LMEM,   "R12 lw read held");
    step(6'b100011, 0, 1, V_LWB,    "R13 lw wb wait ignored");
    // R11 store with a stalled write
    step(6'b101011, 0, 0, V_FETCH,  "R8 fetch");
    step(6'b101011, 0, 1, V_DEC,    "R13 decode wait ignored");
    step(6'b101011, 0, 0, V_AEX,    "R11 sw addr");
    step(6'b101011, 0, 1, V_SMEM,   "R12 sw write stalled");
    step(6'b101011, 0, 0, V_SMEM,   "R12 sw write held");
    // R9 branch not taken, then taken
    step(6'b000100, 0, 0, V_FETCH,  "R8 fetch");
    step(6'b000100, 0, 0, V_DEC,    "R8 decode");
    step(6'b000100, 0, 0, V_BNT,    "R9 beq not taken");
    step(6'b000100, 1, 0, V_FETCH,  "R6 return to fetch");
    step(6'b000100, 1, 0, V_DEC,    "R8 decode");
    step(6'b000100, 1, 1, V_BT,     "R9 beq taken R13 wait ignored");
    // R7 unknown opcode dispatches to fetch
    step(6'b111111, 0, 0, V_FETCH,  "R8 fetch");
    step(6'b111111, 0, 0, V_DEC,    "R7 decode");
    step(6'b111111, 0, 0, V_FETCH,  "R7 unknown opcode to fetch");
    step(6'b000000, 0, 0, V_DEC,    "R6 step after fetch");
    step(6'b000000, 0, 0, V_REX,    "R2 R3 field decode");
    step(6'b000000, 0, 0, V_RWB,    "R4 dest decode");
    step(6'b000000, 0, 0, V_FETCH,  "R6 return to fetch");

    @(posedge clk); #1;
    mwait = 1'b1;
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule